// File: doc/BRIEF.md
# Downstream Port Hot Reset Sequencer

This block runs hot resets for a switch that has one upstream port and a set of downstream ports. It watches configuration writes that target the secondary-bus-reset bit of each port's bridge control register. A one written to the upstream port's bit resets every downstream port together. A one written to a single downstream port's bit resets only that port.

Each downstream port has its own sequence. The port first asks its link layer to send a hot-reset message to the link partner. It then waits for the link layer to report that the message has gone out. Only after that does it assert the port's logic and physical-layer reset, for a programmable number of cycles. A release cycle follows before the port goes idle again.

A reset started from the upstream port also clears the port's ordinary register fields. Sticky fields and lock-protected writable fields are left out of that clear. A reset started locally on one port leaves that port's configuration registers untouched. The sequencer has no output toward the serial EEPROM loader, the PLLs, the SerDes or the SMBus logic. It also has no output toward the upstream port's configuration registers, so none of these can be disturbed by a downstream hot reset.

Top module: `ds_hot_reset_seq`

## Requirements
- R1: A write with data one to port index 0 (the upstream port) starts the sequence on every idle downstream port in the same cycle. `msg_req` rises on all of them one cycle after the write.
- R2: A write with data one to port index k, where 1 ≤ k ≤ NUM_DS, starts the sequence only on downstream port k-1 (bit k-1 of the per-port vectors).
- R3: A write with data zero, or a write to an index above NUM_DS, starts nothing.
- R4: `msg_req` is a one-cycle pulse in the cycle after the trigger. A port never asserts `port_rst` until `msg_sent` has been sampled high after that pulse. A `msg_sent` pulse seen while the port is idle, or during the request cycle itself, has no effect.
- R5: `port_rst` rises in the cycle after `msg_sent` is sampled in the waiting state. It then stays high for exactly the hold length: `hold_cfg` cycles, or 16 when `hold_cfg` is zero.
- R6: `field_clr`, which clears the non-sticky, non-locked register fields, is high together with `port_rst` only for a reset started by an upstream write. It stays low for a locally started reset.
- R7: A trigger that reaches a port that is already busy is ignored. It neither restarts nor lengthens that port's sequence.
- R8: `busy` is high from the cycle after the trigger through one release cycle after `port_rst` falls, and is low otherwise.
- R9: While reset is active and after it ends, all outputs are low until a trigger arrives.
- R10: The hold length is captured when `port_rst` rises. A change to `hold_cfg` during the hold does not change that hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | A write to a secondary-bus-reset bit is present this cycle |
| cfg_wr_port | input | PW | Target port: 0 is upstream, 1..NUM_DS are downstream |
| cfg_wr_data | input | 1 | Value written to the bit |
| hold_cfg | input | HOLD_W | Reset hold length in cycles; 0 selects the default |
| msg_sent | input | NUM_DS | Per port: the hot-reset message has been sent |
| msg_req | output | NUM_DS | Per port: request the link layer to send a hot-reset message |
| port_rst | output | NUM_DS | Per port: logic and physical-layer reset |
| field_clr | output | NUM_DS | Per port: return non-sticky, non-locked fields to their defaults |
| busy | output | NUM_DS | Per port: reset sequence in progress |

## Verification
The hardest case to reach is a port caught in the middle of its sequence while new triggers arrive. In that case one port ignores a write while its neighbours accept it, so port sequences become staggered in phase. The bench holds back the message-sent reply of one chosen port, leaving that port waiting. It then issues both an upstream write and a local write, and changes `hold_cfg` during an active hold. A behavioural model, compared on every clock, then has to agree with every port's phase.

// File: rtl/ds_hot_reset_seq.sv
module ds_hot_reset_seq #(
  parameter int NUM_DS   = 4,
  parameter int HOLD_W   = 8,
  parameter int DEF_HOLD = 16,
  localparam int PW      = $clog2(NUM_DS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [PW-1:0]     cfg_wr_port,
  input  logic              cfg_wr_data,
  input  logic [HOLD_W-1:0] hold_cfg,
  input  logic [NUM_DS-1:0] msg_sent,
  output logic [NUM_DS-1:0] msg_req,
  output logic [NUM_DS-1:0] port_rst,
  output logic [NUM_DS-1:0] field_clr,
  output logic [NUM_DS-1:0] busy
);

  typedef enum logic [2:0] {S_IDLE, S_SEND, S_WAIT, S_RST, S_REL} st_t;

  logic [HOLD_W-1:0] hold_eff;
  logic              up_hit;

  assign hold_eff = (hold_cfg == '0) ? HOLD_W'(DEF_HOLD) : hold_cfg;
  assign up_hit   = cfg_wr_en && cfg_wr_data && (cfg_wr_port == '0);

  for (genvar i = 0; i < NUM_DS; i++) begin : g_port
    st_t               st;
    logic [HOLD_W-1:0] cnt;
    logic              glob;
    logic              hit;

    assign hit = up_hit ||
                 (cfg_wr_en && cfg_wr_data && (cfg_wr_port == PW'(i + 1)));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st   <= S_IDLE;
        cnt  <= '0;
        glob <= 1'b0;
      end else begin
        case (st)
          S_IDLE: if (hit) begin
            st   <= S_SEND;
            glob <= up_hit;
          end
          S_SEND: st <= S_WAIT;
          S_WAIT: if (msg_sent[i]) begin
            st  <= S_RST;
            cnt <= hold_eff;
          end
          S_RST: begin
            if (cnt <= 1) st <= S_REL;
            else          cnt <= cnt - 1'b1;
          end
          default: st <= S_IDLE;
        endcase
      end
    end

    assign msg_req[i]   = (st == S_SEND);
    assign port_rst[i]  = (st == S_RST);
    assign field_clr[i] = (st == S_RST) && glob;
    assign busy[i]      = (st != S_IDLE);

    AST_RST_AFTER_SENT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(port_rst[i]) |-> $past(msg_sent[i])); // R4
    AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      msg_req[i] |=> !msg_req[i]); // R4
    AST_CLR_INSIDE_RST: assert property (@(posedge clk) disable iff (!rst_n)
      field_clr[i] |-> port_rst[i]); // R6
    AST_BUSY_COVERS_RST: assert property (@(posedge clk) disable iff (!rst_n)
      port_rst[i] |-> busy[i]); // R8
    AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(msg_req[i]) |-> !$past(busy[i])); // R7
    AST_CLR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (port_rst[i] && $past(port_rst[i])) |-> $stable(field_clr[i])); // R6
  end

endmodule

// File: tb/tb_ds_hot_reset_seq.sv
module tb_ds_hot_reset_seq;
  localparam int N = 4;
  localparam int HW = 8;
  localparam int PW = $clog2(N + 1);

  logic clk = 0, rst_n = 0;
  logic cfg_wr_en = 0, cfg_wr_data = 0;
  logic [PW-1:0] cfg_wr_port = '0;
  logic [HW-1:0] hold_cfg = '0;
  logic [N-1:0] msg_sent, resp = '0, spur = '0, block = '0;
  logic [N-1:0] msg_req, port_rst, field_clr, busy;

  assign msg_sent = resp | spur;
  always #2.5 clk = ~clk;

  ds_hot_reset_seq #(.NUM_DS(N), .HOLD_W(HW), .DEF_HOLD(16)) dut (
    .clk, .rst_n, .cfg_wr_en, .cfg_wr_port, .cfg_wr_data, .hold_cfg,
    .msg_sent, .msg_req, .port_rst, .field_clr, .busy);

  int checks = 0, fails = 0;
  int lat[N] = '{1, 3, 2, 4};
  int pend[N] = '{-1, -1, -1, -1};

  // behavioural model: phase 0 idle,1 request,2 waiting,3 holding,4 release
  int ph[N], left[N];
  bit gl[N];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin ph[i] = 0; left[i] = 0; gl[i] = 0; end
    end else begin
      for (int i = 0; i < N; i++) begin
        bool_step(i);
      end
    end
  end

  task automatic bool_step(int i);
    bit up, mine;
    up   = cfg_wr_en && cfg_wr_data && cfg_wr_port == 0;
    mine = cfg_wr_en && cfg_wr_data && cfg_wr_port == i + 1;
    if (ph[i] == 0) begin
      if (up || mine) begin ph[i] = 1; gl[i] = up; end
    end else if (ph[i] == 1) ph[i] = 2;
    else if (ph[i] == 2) begin
      if (msg_sent[i]) begin ph[i] = 3; left[i] = (hold_cfg == 0) ? 16 : int'(hold_cfg); end
    end else if (ph[i] == 3) begin
      left[i]--;
      if (left[i] == 0) ph[i] = 4;
    end else ph[i] = 0;
  endtask

  task automatic chk(string req, string what, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s got %0d expected %0d at %0t", req, what, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < N; i++) begin
        chk("R4", $sformatf("msg_req[%0d]", i), msg_req[i], ph[i] == 1);
        chk("R5", $sformatf("port_rst[%0d]", i), port_rst[i], ph[i] == 3);
        chk("R6", $sformatf("field_clr[%0d]", i), field_clr[i], ph[i] == 3 && gl[i]);
        chk("R8", $sformatf("busy[%0d]", i), busy[i], ph[i] != 0);
      end
    end
    for (int i = 0; i < N; i++) begin
      resp[i] = 0;
      if (pend[i] == 0 && !block[i]) begin resp[i] = 1; pend[i] = -1; end
      else if (pend[i] > 0) pend[i]--;
      if (msg_req[i]) pend[i] = lat[i];
    end
  end

  task automatic wr(int port, bit data);
    @(negedge clk);
    cfg_wr_en = 1; cfg_wr_port = PW'(port); cfg_wr_data = data;
    @(negedge clk);
    cfg_wr_en = 0; cfg_wr_data = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run;
    idle(2);
    // R9: outputs low after reset
    chk("R9", "outputs after reset", {msg_req, port_rst, field_clr, busy}, 0);
    rst_n = 1;
    idle(2);
    chk("R9", "outputs idle", {msg_req, port_rst, field_clr, busy}, 0);

    // R1: upstream write, default hold of 16
    wr(0, 1);
    chk("R1", "msg_req all", msg_req, 4'b1111);
    idle(40);

    // R2: local reset of downstream port 1 only
    hold_cfg = 5;
    wr(2, 1);
    chk("R2", "msg_req only port1", msg_req, 4'b0010);
    idle(20);

    // R3: zero data and out-of-range index do nothing
    wr(1, 0);
    chk("R3", "busy after zero write", busy, 0);
    wr(6, 1);
    chk("R3", "busy after bad index", busy, 0);

    // R4: stray msg_sent in idle has no effect
    @(negedge clk); spur = 4'b0100; @(negedge clk); spur = 0;
    idle(2);
    chk("R4", "no reset from stray sent", port_rst, 0);

    // R7: port 0 stalled in waiting, then more triggers
    block = 4'b0001;
    wr(1, 1);
    idle(3);
    wr(1, 1);
    chk("R7", "no second request port0", msg_req[0], 0);
    wr(0, 1);
    chk("R7", "others start, port0 ignored", msg_req, 4'b1110);
    idle(6);
    block = 0;
    idle(30);

    // R10: hold_cfg changes during hold
    hold_cfg = 3;
    wr(3, 1);
    idle(4);
    hold_cfg = 9;
    idle(20);
    hold_cfg = 2;
    lat = '{1, 1, 1, 1};
    wr(0, 1);
    idle(4);
    wr(4, 1);
    idle(20);
    chk("R8", "all idle at end", busy, 0);
  endtask

  initial begin
    fork
      run();
      begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule